// File: doc/BRIEF.md
# Traceback Viterbi Decoder (K=3, rate 1/2, hard decision)

The block decodes one frame of eight hard-decision symbols that a rate 1/2 convolutional encoder with three taps produced. Each 2-bit symbol is taken on a valid/ready handshake. For every accepted symbol the add-compare-select stage updates four path metrics, using the Hamming distance to each branch's expected symbol. It also writes one selection bit per state into a small decision store, indexed by trellis step. The survivor bit sequences themselves are never stored.

After the eighth symbol, the controller latches the state that holds the smallest path metric; on a tie the lowest state number wins. It then walks the decision store backward, one step per clock. In state s with stored bit d, the previous state is ((s<<1)|d) mod 4, and the bit decoded at that step is the MSB of s. The bits come out newest first. Each one is written into its own slot of a reversal buffer, so the byte leaves in transmission order. Input is stalled while the walk runs.

The controller has three states. LOAD accepts symbols, with ready high. TRACE walks back from step 7 to step 0. EMIT pulses done for one cycle and re-initialises the metrics. The transitions are: LOAD to TRACE when the eighth symbol is accepted, TRACE to EMIT after the step-0 read, and EMIT to LOAD unconditionally.

Top module: `vit_trace_decoder`

## Requirements
- R1: During and right after reset, sym_ready is 1, dec_done is 0 and dec_data is 0.
- R2: The encoder starts each frame in the all-zero state. With u the current bit and u1, u2 the two previous bits, sym_in[1] = u^u1^u2 and sym_in[0] = u^u2. With error-free symbols, dec_data[t] equals the bit sent at step t, where step 0 is the first symbol.
- R3: A single flipped bit in any one of symbols 0 to 6 of a frame is corrected, and dec_data still equals the sent byte.
- R4: After the eighth symbol is accepted, sym_ready stays 0 until dec_done. Symbols offered while sym_ready is 0 are not taken and do not affect any later frame.
- R5: dec_done is high for exactly one cycle. It rises on the 8th rising edge after the edge that accepts the frame's last symbol.
- R6: dec_data changes only in the cycle in which dec_done is high, and holds its value otherwise.
- R7: Frames are decoded independently: a frame decodes correctly whatever state the previous frame ended in.
- R8: sym_ready is 1 in the cycle right after dec_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_in | input | 2 | Received symbol: bit 1 from taps 111, bit 0 from taps 101 |
| sym_valid | input | 1 | sym_in holds a symbol |
| sym_ready | output | 1 | A symbol is taken on an edge where valid and ready are both high |
| dec_data | output | FRAME_LEN | Decoded frame, bit t = step t |
| dec_done | output | 1 | One-cycle pulse, dec_data is new |

## Verification
The bench builds the block with its defaults: constraint length 3, generator taps 111 and 101, and a frame of 8 steps. With these values the trellis distances are small enough to work by hand, so every single-bit error position from symbol 0 through 6 can be listed as a case that must correct. The known tie risk in the last symbol stays out of scope. A frame length of 8 also keeps the eight-cycle walk short, so the latency and the stall window during it can be checked cycle by cycle against an accept-cycle record.

// File: rtl/vit_pkg.sv
package vit_pkg;

    // Controller phases of the traceback decoder
    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_TRACE = 2'd1,
        PH_EMIT  = 2'd2
    } phase_t;

endpackage

// File: rtl/vit_bmu.sv
// Branch metric unit: Hamming distance of the received symbol to the
// expected symbol of every (state, decision) branch.
module vit_bmu #(
    parameter int K    = 3,
    parameter int G_HI = 7,
    parameter int G_LO = 5
) (
    input  logic [1:0] sym,
    output logic [1:0] bm [2*(1<<(K-1))]
);
    localparam int M  = K - 1;
    localparam int NS = 1 << M;

    for (genvar s = 0; s < NS; s++) begin : g_state
        for (genvar d = 0; d < 2; d++) begin : g_dec
            // encoder register contents on this branch: {new state, oldest bit}
            localparam int  REGS = s * 2 + d;
            localparam bit  EH   = ^(G_HI & REGS);
            localparam bit  EL   = ^(G_LO & REGS);
            assign bm[s*2+d] = {1'b0, sym[1] ^ EH} + {1'b0, sym[0] ^ EL};
        end
    end

endmodule

// File: rtl/vit_acs.sv
// Add-compare-select over all states; emits one decision bit per state
// and the index of the smallest updated metric.
module vit_acs #(
    parameter int K         = 3,
    parameter int FRAME_LEN = 8,
    parameter int MW        = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 clear,
    input  logic [1:0]           bm   [2*(1<<(K-1))],
    output logic [(1<<(K-1))-1:0] dec,
    output logic [K-2:0]         best
);
    localparam int M  = K - 1;
    localparam int NS = 1 << M;
    localparam logic [MW-1:0] PEN = MW'(2 * FRAME_LEN + 1);

    logic [MW-1:0] pm    [NS];
    logic [MW-1:0] pm_nx [NS];
    logic [MW-1:0] cur_min;

    for (genvar s = 0; s < NS; s++) begin : g_acs
        localparam int P0 = (s << 1) & (NS - 1);
        localparam int P1 = ((s << 1) | 1) & (NS - 1);
        logic [MW-1:0] cand0, cand1;
        assign cand0     = pm[P0] + MW'(bm[s*2]);
        assign cand1     = pm[P1] + MW'(bm[s*2+1]);
        assign dec[s]    = (cand1 < cand0);
        assign pm_nx[s]  = dec[s] ? cand1 : cand0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : PEN;
        end else if (step) begin
            for (int i = 0; i < NS; i++) pm[i] <= pm_nx[i];
        end
    end

    always_comb begin
        logic [MW-1:0] bv;
        bv   = pm_nx[0];
        best = '0;
        for (int i = 1; i < NS; i++) begin
            if (pm_nx[i] < bv) begin
                bv   = pm_nx[i];
                best = M'(i);
            end
        end
    end

    always_comb begin
        cur_min = pm[0];
        for (int i = 1; i < NS; i++) if (pm[i] < cur_min) cur_min = pm[i];
    end

    // R3: the best metric never falls and grows by at most one full symbol
    a_r3_metric_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_min >= $past(cur_min)) &&
                 ({1'b0, cur_min} <= {1'b0, $past(cur_min)} + (MW+1)'(2)));

endmodule

// File: rtl/vit_decmem.sv
// Decision store: one word of per-state selection bits per trellis step.
module vit_decmem #(
    parameter int NS    = 4,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [NS-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [NS-1:0] rdata
);
    logic [NS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/vit_trace_decoder.sv
module vit_trace_decoder
    import vit_pkg::*;
#(
    parameter int K         = 3,
    parameter int FRAME_LEN = 8,
    parameter int G_HI      = 7,
    parameter int G_LO      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           sym_in,
    input  logic                 sym_valid,
    output logic                 sym_ready,
    output logic [FRAME_LEN-1:0] dec_data,
    output logic                 dec_done
);
    localparam int M  = K - 1;
    localparam int NS = 1 << M;
    localparam int AW = $clog2(FRAME_LEN);
    localparam int MW = $clog2(4 * FRAME_LEN + 2);
    localparam logic [AW-1:0] LAST = AW'(FRAME_LEN - 1);

    phase_t               phase, phase_nx;
    logic [AW-1:0]        step_idx;
    logic [M-1:0]         trace_st;
    logic [FRAME_LEN-1:0] out_buf;
    logic [1:0]           bm [2*NS];
    logic [NS-1:0]        dec, rdata;
    logic [M-1:0]         best;
    logic                 take, is_last;

    assign take    = sym_valid && sym_ready;
    assign is_last = (step_idx == LAST);

    vit_bmu #(.K(K), .G_HI(G_HI), .G_LO(G_LO)) u_bmu (
        .sym (sym_in),
        .bm  (bm)
    );

    vit_acs #(.K(K), .FRAME_LEN(FRAME_LEN), .MW(MW)) u_acs (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (take),
        .clear (phase == PH_EMIT),
        .bm    (bm),
        .dec   (dec),
        .best  (best)
    );

    vit_decmem #(.NS(NS), .DEPTH(FRAME_LEN), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (take),
        .waddr (step_idx),
        .wdata (dec),
        .raddr (step_idx),
        .rdata (rdata)
    );

    // next-phase logic
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_LOAD:  if (take && is_last)  phase_nx = PH_TRACE;
            PH_TRACE: if (step_idx == '0)   phase_nx = PH_EMIT;
            PH_EMIT:                        phase_nx = PH_LOAD;
            default:                        phase_nx = PH_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_LOAD;
        else        phase <= phase_nx;
    end

    // outputs decoded from the phase
    always_comb begin
        sym_ready = (phase == PH_LOAD);
        dec_done  = (phase == PH_EMIT);
    end

    // step counter, traceback walk and reversal buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_idx <= '0;
            trace_st <= '0;
            out_buf  <= '0;
            dec_data <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: begin
                    if (take) begin
                        if (is_last) trace_st <= best;
                        else         step_idx <= step_idx + 1'b1;
                    end
                end
                PH_TRACE: begin
                    out_buf[step_idx] <= trace_st[M-1];
                    trace_st          <= {trace_st[M-2:0], rdata[trace_st]};
                    if (step_idx == '0)
                        dec_data <= {out_buf[FRAME_LEN-1:1], trace_st[M-1]};
                    else
                        step_idx <= step_idx - 1'b1;
                end
                PH_EMIT: ;
                default: ;
            endcase
        end
    end

    // R5: done is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);

    // R8: input opens right after done
    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> sym_ready);

    // R4: ready only comes back through the done pulse
    a_r4_ready_via_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_ready) |-> $past(dec_done));

    // R6: decoded byte only moves together with done
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_done |-> $stable(dec_data));

endmodule

// File: tb/vit_trace_decoder_tb.sv
`timescale 1ns/1ps
module vit_trace_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] sym_in;
    logic       sym_valid;
    logic       sym_ready;
    logic [7:0] dec_data;
    logic       dec_done;

    always #2.5 clk = ~clk;

    vit_trace_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_in    (sym_in),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .dec_data  (dec_data),
        .dec_done  (dec_done)
    );

    int         checks = 0;
    int         errors = 0;
    int         cyc    = 0;
    bit         started = 1'b0;
    bit         prev_done = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    int         acc_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // reference encoder written from R2
    function automatic logic [15:0] encode(input logic [7:0] msg);
        logic [15:0] o;
        logic u1, u2;
        u1 = 1'b0; u2 = 1'b0; o = '0;
        for (int t = 0; t < 8; t++) begin
            o[2*t+1] = msg[t] ^ u1 ^ u2;
            o[2*t]   = msg[t] ^ u2;
            u2 = u1;
            u1 = msg[t];
        end
        return o;
    endfunction

    // driver: pushes the expected byte, then feeds the frame
    task automatic send_frame(input logic [7:0] msg, input int err_pos,
                              input int err_bit, input string tag, input bit junk);
        logic [15:0] syms;
        syms = encode(msg);
        if (err_pos >= 0) syms[2*err_pos+err_bit] = ~syms[2*err_pos+err_bit];
        exp_q.push_back(msg);
        tag_q.push_back(tag);
        for (int t = 0; t < 8; t++) begin
            sym_valid = 1'b1;
            sym_in    = syms[2*t +: 2];
            while (!sym_ready) @(negedge clk);
            if (t == 7) acc_q.push_back(cyc + 1);
            @(negedge clk);
        end
        // offer garbage while the walk runs (R4)
        while (!sym_ready) begin
            sym_valid = junk;
            sym_in    = 2'($urandom);
            @(negedge clk);
        end
        sym_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (started && rst_n) begin
            if (acc_q.size() > 0 && !dec_done && cyc >= acc_q[0] && cyc < acc_q[0] + 8)
                check(!sym_ready, "R4", "ready during walk", sym_ready, 0);
            if (dec_done) begin
                logic [7:0] e;
                string      tg;
                int         a;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                a  = acc_q.pop_front();
                check(dec_data == e, tg, "decoded byte", dec_data, e);
                check(cyc - a == 8, "R5", "done latency", cyc - a, 8);
                last_data = dec_data;
                prev_done = 1'b1;
            end else begin
                if (prev_done) begin
                    check(sym_ready, "R8", "ready after done", sym_ready, 1);
                    check(!dec_done, "R5", "done width", dec_done, 0);
                end
                check(dec_data == last_data, "R6", "data hold", dec_data, last_data);
                prev_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r3_msgs [3];
        r3_msgs[0] = 8'h16;
        r3_msgs[1] = 8'hC9;
        r3_msgs[2] = 8'h3E;
        rst_n     = 1'b0;
        sym_valid = 1'b0;
        sym_in    = 2'b00;
        repeat (3) @(negedge clk);
        check(sym_ready && !dec_done && dec_data == 8'h00, "R1", "in reset",
              {sym_ready, dec_done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_ready == 1'b1, "R1", "ready after reset", sym_ready, 1);
        check(dec_done == 1'b0, "R1", "done after reset", dec_done, 0);
        check(dec_data == 8'h00, "R1", "data after reset", dec_data, 0);
        started = 1'b1;

        // R2: clean frames of several patterns
        send_frame(8'h00, -1, 0, "R2", 1'b0);
        send_frame(8'hFF, -1, 0, "R2", 1'b1);
        send_frame(8'hA5, -1, 0, "R2", 1'b0);
        send_frame(8'h16, -1, 0, "R2", 1'b1);
        send_frame(8'h5A, -1, 0, "R2", 1'b0);
        // R7: frame ending in state 3, then one that starts from zero
        send_frame(8'hC0, -1, 0, "R7", 1'b0);
        send_frame(8'h01, -1, 0, "R7", 1'b0);
        send_frame(8'hC3, -1, 0, "R7", 1'b1);
        send_frame(8'h02, -1, 0, "R7", 1'b0);
        // R3: one flipped bit, every symbol 0..6, both bit positions
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 7; p++)
                for (int b = 0; b < 2; b++)
                    send_frame(r3_msgs[m], p, b, "R3", (p % 2) == 1);
        // R4: frame after heavy junk still correct
        send_frame(8'h69, -1, 0, "R4", 1'b1);
        send_frame(8'h96, -1, 0, "R4", 1'b1);

        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule